// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between a serial-memory protocol engine and a synchronous byte array. The engine first loads a start address. It then hands over received data bytes on a valid/ready stream. When the bus transfer closes, it pulses a commit input. The block keeps one page of bytes, each with its own valid flag. The address pointer advances after every accepted byte, but only its low offset bits count, so the pointer wraps inside the page and never leaves it. A byte that arrives after the page is full lands in a slot that was filled earlier and replaces it.

Nothing is written to the array when a byte arrives. At commit, the block scans the page and issues one array write for each slot that holds a byte. The write goes to that byte's own address. For a programmable number of system clocks after the commit, the block holds a busy flag, and while busy it refuses bytes, address loads and further commits. A write-protect input refuses data bytes and blocks the start of a write cycle.

Back-pressure rules for the byte stream: a byte is taken only in a cycle where `byte_valid` and `byte_ready` are both high. `byte_ready` is low while busy, while write protect is high, and in any cycle where `addr_load` or `commit` is high. A byte offered in such a cycle is simply not taken, and the sender decides whether to offer it again. The array write port has no back-pressure: the array accepts a write in every cycle.

Top module: `page_wr_buf`

## Requirements
- R1: An accepted byte is stored in the page slot chosen by the low log2(PAGE_BYTES) bits of the pointer, and the pointer then advances. Only those low bits count up, wrapping from PAGE_BYTES-1 to 0, and the upper bits stay at the loaded page base.
- R2: When more than PAGE_BYTES bytes are accepted in one transfer, each later byte replaces the earlier byte in the same slot, and only the newest value is written.
- R3: At commit, exactly the slots that received a byte are written, each to the address {page base, slot offset} with its stored value. Addresses in the page that received no byte are left unchanged.
- R4: No array write occurs while bytes are being collected; writes occur only during the busy period that follows a commit.
- R5: An accepted commit raises `busy` in the next cycle and keeps it high for exactly max(WR_CYCLES, PAGE_BYTES) cycles. While busy, `byte_ready` is low, and `addr_load`, `commit` and byte offers have no effect.
- R6: A commit made with no accepted byte since the last address load or commit, or made while `wr_protect` is high, never raises `busy` and writes nothing. It also discards any buffered bytes.
- R7: While `wr_protect` is high, `byte_ready` is low.
- R8: A byte offered in the same cycle as `commit` or `addr_load` is not accepted. It is neither written nor counted in the pointer.
- R9: `addr_load` sets the pointer to `addr_in` and empties the page. After a write cycle, the pointer equals the address of the last accepted byte plus one, wrapped within the page.
- R10: After reset, `busy` is low, `byte_ready` is high, the pointer is zero and no array write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load start address and empty the page |
| addr_in | input | ADDR_W | Start address for the transfer |
| byte_valid | input | 1 | A data byte is offered |
| byte_ready | output | 1 | The block accepts an offered byte this cycle |
| byte_data | input | DATA_W | Offered data byte |
| commit | input | 1 | Transfer end pulse; starts the write cycle |
| wr_protect | input | 1 | Refuse bytes and block write cycles |
| busy | output | 1 | Write cycle in progress |
| ptr | output | ADDR_W | Current address pointer |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
Three events can fall in the same cycle: a byte offer, the commit pulse, and an address load. The bench raises `byte_valid` together with `commit` after a few bytes, and separately together with `addr_load`. It judges the result by the number of array writes, the content of the addressed page, and the final pointer. In both cases the stray byte must leave no trace. A second overlap is tested by driving loads, bytes and commits into the busy window. After busy falls, the bench checks that the pointer has not moved and that no second cycle follows.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
  parameter int ADDR_W = 8,
  parameter int PG_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam int HI_W = ADDR_W - PG_W;

  logic [HI_W-1:0] base_q;
  logic [PG_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      base_q <= load_addr[ADDR_W-1:PG_W];
      off_q  <= load_addr[PG_W-1:0];
    end else if (advance) begin
      off_q  <= off_q + PG_W'(1);
    end
  end

  assign ptr_q = {base_q, off_q};
endmodule

// File: rtl/pwb_slots.sv
module pwb_slots #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int PG_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [PG_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PG_W-1:0]   rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        data_q[g]  <= '0;
      end else if (clear) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == PG_W'(g))) begin
        valid_q[g] <= 1'b1;
        data_q[g]  <= wr_data;
      end
    end
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_valid  = valid_q[rd_idx];
  assign any_valid = |valid_q;
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int PG_W       = 4,
  parameter int EFF_CYC    = 16,
  parameter int CNT_W      = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_req,
  input  logic            have_data,
  input  logic            protect,
  output logic            busy_q,
  output logic            scan_active,
  output logic [PG_W-1:0] scan_idx,
  output logic            slots_clear
);
  localparam logic [PG_W-1:0]  LAST_IDX = PG_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_TMR = CNT_W'(EFF_CYC - 1);

  seq_state_t      st_q;
  logic [PG_W-1:0] idx_q;
  logic [CNT_W-1:0] tmr_q;
  logic            start;

  assign start = (st_q == SEQ_IDLE) && commit_req && have_data && !protect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          idx_q <= '0;
          tmr_q <= '0;
          if (start) st_q <= SEQ_SCAN;
        end
        SEQ_SCAN: begin
          idx_q <= idx_q + PG_W'(1);
          tmr_q <= tmr_q + CNT_W'(1);
          if (tmr_q == LAST_TMR)      st_q <= SEQ_IDLE;
          else if (idx_q == LAST_IDX) st_q <= SEQ_HOLD;
        end
        SEQ_HOLD: begin
          tmr_q <= tmr_q + CNT_W'(1);
          if (tmr_q == LAST_TMR) st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_q      = (st_q != SEQ_IDLE);
  assign scan_active = (st_q == SEQ_SCAN);
  assign scan_idx    = idx_q;
  assign slots_clear = ((st_q == SEQ_SCAN) && (idx_q == LAST_IDX)) ||
                       ((st_q == SEQ_IDLE) && commit_req && !start);
endmodule

// File: rtl/page_wr_buf.sv
module page_wr_buf #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              commit,
  input  logic              wr_protect,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PG_W    = $clog2(PAGE_BYTES);
  localparam int EFF_CYC = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
  localparam int CNT_W   = $clog2(EFF_CYC + 1);

  logic            load_ok, take_byte, seq_clear, slot_clear;
  logic            have_data, scan_active, rd_valid;
  logic [PG_W-1:0] scan_idx;
  logic [DATA_W-1:0] rd_data;

  assign load_ok    = addr_load && !busy;
  assign byte_ready = !busy && !wr_protect && !addr_load && !commit;
  assign take_byte  = byte_valid && byte_ready;
  assign slot_clear = seq_clear || load_ok;

  pwb_pointer #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .load_addr(addr_in),
    .advance  (take_byte),
    .ptr_q    (ptr)
  );

  pwb_slots #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .PG_W(PG_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (slot_clear),
    .wr_en    (take_byte),
    .wr_idx   (ptr[PG_W-1:0]),
    .wr_data  (byte_data),
    .rd_idx   (scan_idx),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .any_valid(have_data)
  );

  pwb_seq #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W), .EFF_CYC(EFF_CYC), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_req (commit),
    .have_data  (have_data),
    .protect    (wr_protect),
    .busy_q     (busy),
    .scan_active(scan_active),
    .scan_idx   (scan_idx),
    .slots_clear(seq_clear)
  );

  assign mem_we    = scan_active && rd_valid;
  assign mem_addr  = {ptr[ADDR_W-1:PG_W], scan_idx};
  assign mem_wdata = rd_data;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W  = 8,
  parameter int PG_W    = 4,
  parameter int EFF_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              wr_protect,
  input logic              byte_ready,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready); // R5
  AST_READY_LOW_WP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> !byte_ready); // R7
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R4
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr)); // R5
  AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:PG_W] == ptr[ADDR_W-1:PG_W])); // R3
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit)); // R5
  AST_PROTECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_protect && !busy) |=> !busy); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == EFF_CYC)); // R5
endmodule

bind page_wr_buf pwb_checker #(.ADDR_W(ADDR_W), .PG_W(PG_W), .EFF_CYC(EFF_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .commit    (commit),
  .wr_protect(wr_protect),
  .byte_ready(byte_ready),
  .busy      (busy),
  .ptr       (ptr),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/sim_page_wr_buf.sv
`timescale 1ns/1ps
module sim_page_wr_buf;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PB = 16;
  localparam int WRC = 24;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, byte_valid = 0, commit = 0, wr_protect = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] byte_data = '0;
  logic byte_ready, busy, mem_we;
  logic [AW-1:0] ptr, mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0, errors = 0;
  int wcount = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] expm [256];

  always #10 clk = ~clk;

  page_wr_buf #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .commit(commit), .wr_protect(wr_protect), .busy(busy), .ptr(ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) if (rst_n && mem_we) begin
    mem[mem_addr] = mem_wdata;
    wcount++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_load(input logic [AW-1:0] a);
    addr_load = 1; addr_in = a; tick(); addr_load = 0;
  endtask

  task automatic send(input logic [DW-1:0] d);
    byte_valid = 1; byte_data = d; tick(); byte_valid = 0;
  endtask

  task automatic commit_wait(output int blen);
    commit = 1; tick(); commit = 0;
    blen = 0;
    while (busy && blen < 1000) begin blen++; tick(); end
  endtask

  function automatic int page_mism(input int base);
    int m = 0;
    for (int i = 0; i < PB; i++) if (mem[base + i] !== expm[base + i]) m++;
    return m;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int blen, wc0, base, cnt, a;
    logic [DW-1:0] bufd [PB];
    bit bufv [PB];
    for (int i = 0; i < 256; i++) begin mem[i] = 0; expm[i] = 0; end
    tick(); tick();
    // R10: reset state
    chk(busy == 0, "R10 busy", busy, 0);
    chk(byte_ready == 1, "R10 ready", byte_ready, 1);
    chk(ptr == 0, "R10 ptr", ptr, 0);
    chk(mem_we == 0, "R10 we", mem_we, 0);
    rst_n = 1; tick();

    // Sweep of start offset and byte count
    for (int s = 0; s < PB; s++) begin
      for (int n = 1; n <= 20; n++) begin
        base = ((s + n) % PB) * PB;
        a = base + s;
        for (int i = 0; i < PB; i++) bufv[i] = 0;
        do_load(a[AW-1:0]);
        chk(ptr == a[AW-1:0], "R9 load", ptr, a);
        wc0 = wcount;
        for (int k = 0; k < n; k++) begin
          logic [DW-1:0] d;
          d = DW'((s * 31 + n * 7 + k * 13 + 5) & 8'hFF);
          send(d);
          bufd[(s + k) % PB] = d;
          bufv[(s + k) % PB] = 1;
        end
        chk(wcount == wc0, "R4 early write", wcount - wc0, 0);
        chk(ptr == AW'(base + (s + n) % PB), "R1 wrap ptr", ptr, base + (s + n) % PB);
        commit_wait(blen);
        chk(blen == WRC, "R5 busy length", blen, WRC);
        cnt = (n < PB) ? n : PB;
        chk(wcount - wc0 == cnt, "R3 write count", wcount - wc0, cnt);
        for (int i = 0; i < PB; i++) if (bufv[i]) expm[base + i] = bufd[i];
        chk(page_mism(base) == 0, (n > PB) ? "R2 overwrite" : "R3 content", page_mism(base), 0);
        chk(ptr == AW'(base + (s + n) % PB), "R9 ptr after", ptr, base + (s + n) % PB);
      end
    end

    // R5: inputs during busy are ignored
    do_load(8'h37); send(8'hA1); send(8'hA2);
    commit = 1; tick(); commit = 0;
    wc0 = wcount;
    for (int i = 0; i < 5; i++) begin
      addr_load = 1; addr_in = 8'hC0; byte_valid = 1; byte_data = 8'h5A; commit = 1;
      #1 chk(byte_ready == 0, "R5 ready low", byte_ready, 0);
      tick();
    end
    addr_load = 0; byte_valid = 0; commit = 0;
    blen = 0;
    while (busy && blen < 1000) begin blen++; tick(); end
    expm[8'h37] = 8'hA1; expm[8'h38] = 8'hA2;
    chk(ptr == 8'h39, "R5 ptr unchanged", ptr, 8'h39);
    chk(wcount - wc0 == 2, "R5 writes", wcount - wc0, 2);
    chk(page_mism(8'h30) == 0 && page_mism(8'hC0) == 0, "R5 content", page_mism(8'hC0), 0);
    tick(); tick();
    chk(busy == 0, "R5 no second cycle", busy, 0);

    // R8: byte with commit in the same cycle
    do_load(8'h53); send(8'h11); send(8'h22);
    wc0 = wcount;
    byte_valid = 1; byte_data = 8'hEE; commit = 1;
    #1 chk(byte_ready == 0, "R8 ready with commit", byte_ready, 1'b0);
    tick(); byte_valid = 0; commit = 0;
    blen = 0;
    while (busy && blen < 1000) begin blen++; tick(); end
    expm[8'h53] = 8'h11; expm[8'h54] = 8'h22;
    chk(wcount - wc0 == 2, "R8 commit writes", wcount - wc0, 2);
    chk(page_mism(8'h50) == 0, "R8 commit content", page_mism(8'h50), 0);
    chk(ptr == 8'h55, "R8 commit ptr", ptr, 8'h55);

    // R8: byte with load in the same cycle
    addr_load = 1; addr_in = 8'h6A; byte_valid = 1; byte_data = 8'h77;
    tick(); addr_load = 0; byte_valid = 0;
    chk(ptr == 8'h6A, "R8 load ptr", ptr, 8'h6A);
    wc0 = wcount;
    commit_wait(blen);
    chk(blen == 0, "R8 load no cycle", blen, 0);
    chk(wcount == wc0, "R8 load no write", wcount - wc0, 0);

    // R6: empty commit
    do_load(8'h80);
    commit_wait(blen);
    chk(blen == 0, "R6 empty commit", blen, 0);

    // R7/R6: write protect
    do_load(8'h90); send(8'h01); send(8'h02); send(8'h03);
    wr_protect = 1;
    #1 chk(byte_ready == 0, "R7 ready under protect", byte_ready, 0);
    send(8'h04);
    chk(ptr == 8'h93, "R7 byte refused", ptr, 8'h93);
    wc0 = wcount;
    commit_wait(blen);
    chk(blen == 0, "R6 protect no busy", blen, 0);
    wr_protect = 0; tick();
    commit_wait(blen);
    chk(blen == 0, "R6 buffer discarded", blen, 0);
    chk(wcount == wc0 && page_mism(8'h90) == 0, "R6 no write", wcount - wc0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule